// File: doc/BRIEF.md
# SerDes Mode and Direction Controller

This controller sits beside a bidirectional parallel-to-serial link and turns a handful of slow, static board-level pins into the enables of the link. Two range-select pins choose the reference-clock frequency band, or power-down when both are low. A direction pin picks between the serializer and deserializer roles. A multiplier pin picks the PLL ratio. From these the block derives role enables, drive and gating controls for the parallel and serial ports, an internal reset and a PLL enable. It also passes the direction pin through inverted, so that the pin can steer a partner device.

All mode pins are asynchronous to the local free-running clock. Each one passes through a two-flop synchroniser before it is decoded, and the decoded strobes are then registered at the outputs. The reference clock is watched by an activity detector. The detector raises a loss flag when no edge arrives within a parameterised number of local clock cycles. The loss flag shuts down the PLL and the serial transmit drivers, and the next reference edge brings them back. A sticky clock-source bit starts at "external bit clock" after every power-up. It moves to "reference clock" at the first reference edge and stays there until the next power-down.

Top module: `serdes_mode_ctrl`

## Requirements
- R1: When the synchronised range code is 00, the block is powered down regardless of direction and multiplier. In that state dirOutEn, serEn, desEn, parInEn, parOutEn, serTxEn, serRxEn, pllEn, pllMult7 and coreRstN are all 0, rangeOut is 00, useRefClk is 0 and refClkLost is 1.
- R2: dirOut is always the combinational inverse of dirIn, even in power-down.
- R3: With a non-zero range code and dirIn = 1 (serializer), serEn = 1, parInEn = 1, parOutEn = 0, desEn = 0 and serRxEn = 0.
- R4: With a non-zero range code and dirIn = 0 (deserializer), desEn = 1, parOutEn = 1, serRxEn = 1, serEn = 0, parInEn = 0 and serTxEn = 0. parInEn and parOutEn are never both 1.
- R5: While active, rangeOut equals the synchronised range code (01 = 20-40 MHz band, 10 = 5-14 MHz, 11 = 8-28 MHz) and pllMult7 equals multSel (1 = 7x, 0 = 7-1/3x). dirOutEn and coreRstN are 1.
- R6: After power-up with no reference edge, useRefClk is 0, refClkLost is 1 and pllEn is 0. In serializer mode serTxEn is 1, because the transmitter runs from the external bit clock.
- R7: The first reference edge while active sets useRefClk to 1. It stays 1 when the reference stops, and only power-down clears it.
- R8: refClkLost rises once LOSS_CYCLES local cycles pass with no reference edge, and it falls after the next edge. While active, pllEn = !refClkLost. When useRefClk is 1 and the reference is lost, serTxEn is 0.
- R9: A change on rangeSel, dirIn or multSel leaves the outputs unchanged for two clock edges and shows at the outputs on the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local free-running clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rangeSel | input | 2 | Frequency-band select; 00 = power-down |
| dirIn | input | 1 | 1 = serializer, 0 = deserializer |
| multSel | input | 1 | PLL ratio select, 1 = 7x, 0 = 7-1/3x |
| refClk | input | 1 | Reference clock, sampled for activity |
| dirOut | output | 1 | Inverse of dirIn |
| dirOutEn | output | 1 | Drive enable for dirOut |
| serEn | output | 1 | Serializer path enable |
| desEn | output | 1 | Deserializer path enable |
| parInEn | output | 1 | Parallel input buffers open |
| parOutEn | output | 1 | Parallel output drivers on and output register writable |
| serTxEn | output | 1 | Serial data/clock drivers enabled |
| serRxEn | output | 1 | Serial receivers and gated termination enabled |
| pllEn | output | 1 | PLL enable |
| pllMult7 | output | 1 | PLL ratio: 1 = 7x, 0 = 7-1/3x |
| rangeOut | output | 2 | Active band code, 00 in power-down |
| coreRstN | output | 1 | Active-low internal reset for the data paths |
| useRefClk | output | 1 | Serializer clock source: 1 = reference, 0 = external bit clock |
| refClkLost | output | 1 | No reference edge within LOSS_CYCLES |

## Verification
The static decode is exercised with random combinations of range code, direction and multiplier while the reference runs. Every step is compared with a bench model, which separates the power-down code from the three active bands and the two roles from each other. Directed sequences then hold the reference off, start it, stop it and restart it. These show the sticky source choice apart from the loss flag: after a stop, useRefClk must stay set while pllEn and serTxEn drop. A single-edge-resolution probe on a range change checks the two-cycle synchroniser latency.

// File: rtl/serdes_ctrl_pkg.sv
package serdes_ctrl_pkg;

  // Decoded strobes passed from the mode decoder to the port datapath
  typedef struct packed {
    logic       powerDown;
    logic       serSel;
    logic       desSel;
    logic       mult7;
    logic [1:0] rangeCode;
  } ctrlStrobes_t;

  localparam logic [1:0] RANGE_OFF = 2'b00;

endpackage

// File: rtl/serdes_bit_sync.sv
module serdes_bit_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : gBit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], asyncIn[b]};
      end
      assign syncOut[b] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/serdes_mode_decode.sv
module serdes_mode_decode
  import serdes_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   rangeSel,
  input  logic         dirIn,
  input  logic         multSel,
  output ctrlStrobes_t strobes
);

  localparam int PIN_W = 4;

  logic [PIN_W-1:0] pinsSync;
  logic [1:0]       rangeS;
  logic             dirS;
  logic             multS;
  logic             pd;

  serdes_bit_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({rangeSel, dirIn, multSel}),
    .syncOut (pinsSync)
  );

  assign rangeS = pinsSync[3:2];
  assign dirS   = pinsSync[1];
  assign multS  = pinsSync[0];
  assign pd     = (rangeS == RANGE_OFF);

  always_comb begin
    strobes.powerDown = pd;
    strobes.serSel    = !pd && dirS;
    strobes.desSel    = !pd && !dirS;
    strobes.mult7     = !pd && multS;
    strobes.rangeCode = pd ? RANGE_OFF : rangeS;
  end

  // R1: the roles are mutually exclusive and both vanish in power-down
  // R1
  role_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.serSel && strobes.desSel) && !(strobes.powerDown && (strobes.serSel || strobes.desSel)));

endmodule

// File: rtl/serdes_port_datapath.sv
module serdes_port_datapath
  import serdes_ctrl_pkg::*;
#(
  parameter int LOSS_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic         refClk,
  output logic         dirOutEn,
  output logic         serEn,
  output logic         desEn,
  output logic         parInEn,
  output logic         parOutEn,
  output logic         serTxEn,
  output logic         serRxEn,
  output logic         pllEn,
  output logic         pllMult7,
  output logic [1:0]   rangeOut,
  output logic         coreRstN,
  output logic         useRefClk,
  output logic         refClkLost
);

  localparam int CNT_W = $clog2(LOSS_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(LOSS_CYCLES);

  logic             refSync;
  logic             refPrev;
  logic             refEdge;
  logic [CNT_W-1:0] idleCnt;
  logic             lostNow;
  logic             useRefQ;
  logic             txAllowed;

  serdes_bit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) uRefSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (refClk),
    .syncOut (refSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) refPrev <= 1'b0;
    else       refPrev <= refSync;
  end

  assign refEdge = refSync ^ refPrev;

  // Idle counter: restarts on every reference edge, saturates at the limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    idleCnt <= CNT_LIMIT;
    else if (strobes.powerDown)   idleCnt <= CNT_LIMIT;
    else if (refEdge)             idleCnt <= '0;
    else if (idleCnt != CNT_LIMIT) idleCnt <= idleCnt + 1'b1;
  end

  assign lostNow = (idleCnt == CNT_LIMIT);

  // Sticky clock-source choice, cleared only by power-down
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  useRefQ <= 1'b0;
    else if (strobes.powerDown) useRefQ <= 1'b0;
    else if (refEdge)           useRefQ <= 1'b1;
  end

  assign txAllowed = !useRefQ || !lostNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirOutEn   <= 1'b0;
      serEn      <= 1'b0;
      desEn      <= 1'b0;
      parInEn    <= 1'b0;
      parOutEn   <= 1'b0;
      serTxEn    <= 1'b0;
      serRxEn    <= 1'b0;
      pllEn      <= 1'b0;
      pllMult7   <= 1'b0;
      rangeOut   <= RANGE_OFF;
      coreRstN   <= 1'b0;
      refClkLost <= 1'b1;
    end else begin
      dirOutEn   <= !strobes.powerDown;
      serEn      <= strobes.serSel;
      desEn      <= strobes.desSel;
      parInEn    <= strobes.serSel;
      parOutEn   <= strobes.desSel;
      serTxEn    <= strobes.serSel && txAllowed;
      serRxEn    <= strobes.desSel;
      pllEn      <= !strobes.powerDown && !lostNow;
      pllMult7   <= strobes.mult7;
      rangeOut   <= strobes.rangeCode;
      coreRstN   <= !strobes.powerDown;
      refClkLost <= lostNow;
    end
  end

  assign useRefClk = useRefQ;

  // R4
  par_dir_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(parInEn && parOutEn));

  // R7
  src_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (useRefQ && !strobes.powerDown) |=> useRefQ);

  // R8
  lost_pll_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    lostNow |=> !pllEn);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    idleCnt <= CNT_LIMIT);

  // R1
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.powerDown |=> (!coreRstN && !serTxEn && !parOutEn && !pllEn && !useRefQ));

endmodule

// File: rtl/serdes_mode_ctrl.sv
module serdes_mode_ctrl
  import serdes_ctrl_pkg::*;
#(
  parameter int LOSS_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] rangeSel,
  input  logic       dirIn,
  input  logic       multSel,
  input  logic       refClk,
  output logic       dirOut,
  output logic       dirOutEn,
  output logic       serEn,
  output logic       desEn,
  output logic       parInEn,
  output logic       parOutEn,
  output logic       serTxEn,
  output logic       serRxEn,
  output logic       pllEn,
  output logic       pllMult7,
  output logic [1:0] rangeOut,
  output logic       coreRstN,
  output logic       useRefClk,
  output logic       refClkLost
);

  ctrlStrobes_t strobes;

  // Direction pass-through is asynchronous so a partner can follow at once
  assign dirOut = !dirIn;

  serdes_mode_decode #(.SYNC_STAGES(SYNC_STAGES)) uDecode (
    .clk      (clk),
    .rstN     (rstN),
    .rangeSel (rangeSel),
    .dirIn    (dirIn),
    .multSel  (multSel),
    .strobes  (strobes)
  );

  serdes_port_datapath #(.LOSS_CYCLES(LOSS_CYCLES), .SYNC_STAGES(SYNC_STAGES)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .refClk     (refClk),
    .dirOutEn   (dirOutEn),
    .serEn      (serEn),
    .desEn      (desEn),
    .parInEn    (parInEn),
    .parOutEn   (parOutEn),
    .serTxEn    (serTxEn),
    .serRxEn    (serRxEn),
    .pllEn      (pllEn),
    .pllMult7   (pllMult7),
    .rangeOut   (rangeOut),
    .coreRstN   (coreRstN),
    .useRefClk  (useRefClk),
    .refClkLost (refClkLost)
  );

  // R2
  dir_inv_chk: assert property (@(posedge clk) disable iff (!rstN)
    dirOut != dirIn);

endmodule

// File: tb/tb_serdes_mode_ctrl.sv
module tb_serdes_mode_ctrl;

  localparam int LOSS = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] rangeSel = 2'b00;
  logic       dirIn = 1'b0;
  logic       multSel = 1'b0;
  logic       refClk = 1'b0;
  logic       dirOut, dirOutEn, serEn, desEn, parInEn, parOutEn, serTxEn, serRxEn;
  logic       pllEn, pllMult7, coreRstN, useRefClk, refClkLost;
  logic [1:0] rangeOut;

  int errors = 0;
  int checks = 0;
  bit refRun = 1'b0;
  int refDiv = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serdes_mode_ctrl #(.LOSS_CYCLES(LOSS)) dut (
    .clk(clk), .rstN(rstN), .rangeSel(rangeSel), .dirIn(dirIn), .multSel(multSel),
    .refClk(refClk), .dirOut(dirOut), .dirOutEn(dirOutEn), .serEn(serEn), .desEn(desEn),
    .parInEn(parInEn), .parOutEn(parOutEn), .serTxEn(serTxEn), .serRxEn(serRxEn),
    .pllEn(pllEn), .pllMult7(pllMult7), .rangeOut(rangeOut), .coreRstN(coreRstN),
    .useRefClk(useRefClk), .refClkLost(refClkLost)
  );

  // Reference clock: toggles every third local cycle while running
  always @(negedge clk) begin
    if (refRun) begin
      refDiv = refDiv + 1;
      if (refDiv >= 3) begin
        refClk = ~refClk;
        refDiv = 0;
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Static outputs {dirOutEn,serEn,desEn,parInEn,parOutEn,serTxEn,serRxEn,pllEn,pllMult7,rangeOut,coreRstN}
  function automatic logic [11:0] expStatic(input logic [1:0] rng, input logic dir, input logic mul);
    logic pd;
    pd = (rng == 2'b00);
    return {!pd, !pd && dir, !pd && !dir, !pd && dir, !pd && !dir, !pd && dir,
            !pd && !dir, !pd, !pd && mul, pd ? 2'b00 : rng, !pd};
  endfunction

  function automatic logic [11:0] actStatic();
    return {dirOutEn, serEn, desEn, parInEn, parOutEn, serTxEn, serRxEn,
            pllEn, pllMult7, rangeOut, coreRstN};
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    step(3);
    // R1: reset state equals power-down
    chk("R1 reset static", actStatic(), 12'h000);
    chk("R1 reset useRefClk", useRefClk, 0);
    chk("R1 reset lost", refClkLost, 1);
    rstN = 1'b1;

    // R1: power-down regardless of direction and multiplier
    dirIn = 1'b1; multSel = 1'b1; step(6);
    chk("R1 pd dir1", actStatic(), 12'h000);
    chk("R2 dirOut in pd", dirOut, 0);
    dirIn = 1'b0; step(6);
    chk("R1 pd dir0", actStatic(), 12'h000);
    chk("R2 dirOut in pd dir0", dirOut, 1);

    // R6: serializer without reference clock uses the external bit clock
    dirIn = 1'b1; multSel = 1'b0; rangeSel = 2'b01; step(8);
    chk("R6 useRefClk", useRefClk, 0);
    chk("R6 lost", refClkLost, 1);
    chk("R6 pllEn", pllEn, 0);
    chk("R6 serTxEn", serTxEn, 1);
    chk("R3 serEn parInEn parOutEn", {serEn, parInEn, parOutEn, desEn, serRxEn}, 5'b11000);

    // R7 / R8: start the reference
    refRun = 1'b1; step(14);
    chk("R7 source switched", useRefClk, 1);
    chk("R8 not lost", refClkLost, 0);
    chk("R8 pllEn running", pllEn, 1);
    chk("R8 serTxEn running", serTxEn, 1);

    // R8 boundary: shortly after the reference stops it is not yet lost
    refRun = 1'b0; step(6);
    chk("R8 early not lost", refClkLost, 0);
    step(LOSS + 6);
    chk("R8 lost after window", refClkLost, 1);
    chk("R8 pll off when lost", pllEn, 0);
    chk("R8 tx off when lost", serTxEn, 0);
    chk("R7 sticky after stop", useRefClk, 1);

    // R8: recovery on the next edge
    refRun = 1'b1; step(12);
    chk("R8 recover lost", refClkLost, 0);
    chk("R8 recover pll", pllEn, 1);
    chk("R8 recover tx", serTxEn, 1);

    // R9: synchroniser latency on a range change
    step(4);
    rangeSel = 2'b00; step(2);
    chk("R9 unchanged after two edges", serEn, 1);
    step(1);
    chk("R9 changed on third edge", serEn, 0);
    step(3);
    chk("R7 cleared by power-down", useRefClk, 0);

    // R7: after power-down with no reference the source stays external
    refRun = 1'b0; step(4);
    rangeSel = 2'b11; step(10);
    chk("R7 external after re-power", useRefClk, 0);
    chk("R6 tx on with bit clock", serTxEn, 1);

    // R4: deserializer disables the serial transmitter
    dirIn = 1'b0; step(6);
    chk("R4 deser enables", {desEn, parOutEn, serRxEn, serEn, parInEn, serTxEn}, 6'b111000);

    // R5 directed: each band with both multipliers
    refRun = 1'b1;
    for (int r = 1; r < 4; r++) begin
      for (int m = 0; m < 2; m++) begin
        rangeSel = r[1:0]; multSel = m[0]; dirIn = 1'b1; step(12);
        chk("R5 band/mult", actStatic(), expStatic(r[1:0], 1'b1, m[0]));
      end
    end

    // R1/R3/R4/R5 random: reference running
    for (int i = 0; i < 60; i++) begin
      logic [1:0] rr;
      logic dd, mm;
      rr = 2'($urandom_range(0, 3));
      dd = 1'($urandom_range(0, 1));
      mm = 1'($urandom_range(0, 1));
      rangeSel = rr; dirIn = dd; multSel = mm;
      step(12);
      chk("R1/R3/R4/R5 random static", actStatic(), expStatic(rr, dd, mm));
      chk("R2 random dirOut", dirOut, !dd);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule